// File: doc/BRIEF.md
# Parallel Peripheral Bus Cycle Controller

This block runs single processor reads and writes on an external byte-wide peripheral bus. The bus has six address lines, eight data lines, three active-low strobes (write direction, write-data latch, read) and an active-high device-ready input. A request from the processor side starts a bus cycle. The block drives the address, and the write data on writes, for a fixed setup time. It then drops the direction strobe. On writes it also drops the data-latch strobe after a further fixed delay. The processor is held in wait for the whole cycle.

The ready input is ignored until a fixed point after the strobe falls. From that point on it is sampled every clock. The cycle ends on the first clock where ready is high. If ready has not arrived when the timeout window expires, the block ends the cycle as though ready had been seen and sets a sticky timeout flag. That flag is also the timeout interrupt, and a processor access to the status register clears it.

A final end cycle releases every strobe while the address is still driven, and the data drivers return to high impedance. The active-low shared device interrupt line is synchronised and passed to the processor side as an active-high signal. All delays are clock-cycle parameters. The defaults suit a 20 ns clock: a 60 ns address setup, 260 ns to the data-latch strobe, first ready sample 760 ns after the strobe, and a 54 µs timeout.

Top module: `pb_bus_ctrl`

## Requirements
- R1: After reset the strobes are high, no output enable is on, cpu_wait, rsp_done and tmo_flag are low.
- R2: A write accepted on an idle clock drives bus_addr and bus_dout with their enables on from the next cycle. bus_wr_n falls SETUP_CYC cycles after the address appears and stays low until the end cycle.
- R3: On a write, bus_out_n falls OUT_DLY cycles after bus_wr_n falls and rises with it. On a read, bus_out_n stays high.
- R4: A read drives the address the same way and pulls bus_rd_n low SETUP_CYC cycles after the address appears. bus_dout_oe stays low throughout a read.
- R5: cpu_wait is high from the cycle after acceptance up to and including the end cycle, and low otherwise.
- R6: bus_rdy is ignored before the clock edge SAMPLE_CYC cycles after the strobe fell. If it is already high then, the end cycle follows that edge.
- R7: If bus_rdy is low at the first sample, the cycle ends after the first later edge at which bus_rdy is high.
- R8: If bus_rdy stays low up to the edge TIMEOUT_CYC cycles after the strobe fell, the cycle ends there anyway and tmo_flag goes high.
- R9: The end cycle lasts exactly one clock. In it rsp_done is high, every strobe is high, the address is still driven and bus_dout_oe is low. On a read, rsp_rdata then holds bus_din as sampled on the ending edge.
- R10: stat_clr clears tmo_flag on the next edge. If a timeout sets the flag on the same edge, the set wins.
- R11: req_valid is ignored while a cycle is in progress. The running cycle's address and data stay unchanged.
- R12: dev_irq equals the inverse of bus_int_n delayed by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a bus cycle (taken only when idle) |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 6 | Peripheral address |
| req_wdata | input | 8 | Write data |
| stat_clr | input | 1 | Processor access to status; clears timeout flag |
| cpu_wait | output | 1 | Hold processor in wait states |
| rsp_done | output | 1 | High during the one end cycle |
| rsp_rdata | output | 8 | Data captured on a read |
| tmo_flag | output | 1 | Sticky timeout status and interrupt |
| dev_irq | output | 1 | Synchronised device interrupt, active high |
| bus_addr | output | 6 | Address lines |
| bus_addr_oe | output | 1 | Address driver enable |
| bus_dout | output | 8 | Data lines, outgoing |
| bus_dout_oe | output | 1 | Data driver enable |
| bus_din | input | 8 | Data lines, incoming |
| bus_wr_n | output | 1 | Write-direction strobe, active low |
| bus_out_n | output | 1 | Write data latch strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rdy | input | 1 | Device ready, active high |
| bus_int_n | input | 1 | Shared device interrupt line, active low |

## Verification
The assertions check on every cycle the properties that hold at each instant. The write and read strobes never overlap, and the data-latch strobe never falls on a read. The data drivers stay off under a read strobe, and the processor is held while any strobe is low. The address does not move during a cycle, and the timeout flag follows its set and clear rules. Only the bench scenarios can show the exact cycle positions of the strobes and the end of the cycle, for early ready, late ready and timeout. They also show a set and a clear arriving on the same edge, and a request that comes while the bus is busy.

// File: rtl/pb_pkg.sv
// Package: shared types for the peripheral bus cycle controller.
// Assumes nothing beyond IEEE 1800-2017.
package pb_pkg;
    // Bus cycle phases: idle, address setup, strobe active, end/release.
    typedef enum logic [1:0] {
        PB_IDLE = 2'd0,
        PB_ADDR = 2'd1,
        PB_STRB = 2'd2,
        PB_END  = 2'd3
    } pb_state_t;
endpackage

// File: rtl/pb_timer.sv
// Module: pb_timer
// Free-running up counter with synchronous clear and count enable.
// Used to time phases of a bus cycle. Assumes the user never lets it wrap.
module pb_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    // Count cycles within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (en)     count <= count + 1'b1;
    end
endmodule

// File: rtl/pb_status.sv
// Module: pb_status
// Holds the sticky timeout flag and synchronises the shared device
// interrupt line. Assumes bus_int_n is asynchronous to clk.
module pb_status #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_set,
    input  logic stat_clr,
    input  logic bus_int_n,
    output logic tmo_flag,
    output logic dev_irq
);
    logic [SYNC_N-1:0] sync_q;

    // Sticky timeout flag: a set beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        tmo_flag <= 1'b0;
        else if (tmo_set)  tmo_flag <= 1'b1;
        else if (stat_clr) tmo_flag <= 1'b0;
    end

    // Synchroniser chain for the inverted interrupt line.
    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ~bus_int_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_N-2:0], ~bus_int_n};
            end
        end
    endgenerate

    assign dev_irq = sync_q[SYNC_N-1];

    // R8: flag only rises after a timeout pulse
    a_r8_flag_from_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(tmo_set));
    // R10: a lone clear drops the flag
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !tmo_set) |=> !tmo_flag);
    // R10: a set wins over a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_set |=> tmo_flag);
endmodule

// File: rtl/pb_seq.sv
// Module: pb_seq
// Bus cycle sequencer: takes a request, drives address/data, times the
// strobes from an external phase counter, samples ready from a fixed point,
// ends on ready or timeout. Assumes bus_rdy and bus_din are synchronous to clk.
module pb_seq
    import pb_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 8,
    parameter int CW          = 12,
    parameter int SETUP_CYC   = 3,
    parameter int OUT_DLY     = 13,
    parameter int SAMPLE_CYC  = 38,
    parameter int TIMEOUT_CYC = 2700
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_rdy,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_en,
    output logic          tmo_set,
    output logic          cpu_wait,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    output logic          bus_wr_n,
    output logic          bus_out_n,
    output logic          bus_rd_n
);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] OUT_AT     = CW'(OUT_DLY);
    localparam logic [CW-1:0] SAMPLE_AT  = CW'(SAMPLE_CYC - 1);
    localparam logic [CW-1:0] TMO_AT     = CW'(TIMEOUT_CYC - 1);

    pb_state_t state, state_nx;
    logic      wr_q;
    logic      finish;
    logic      in_strb;

    assign in_strb = (state == PB_STRB);
    assign finish  = in_strb && (cnt >= SAMPLE_AT) && (bus_rdy || cnt == TMO_AT);

    // Next-state selection for the bus cycle phases.
    always_comb begin
        state_nx = state;
        unique case (state)
            PB_IDLE: if (req_valid)             state_nx = PB_ADDR;
            PB_ADDR: if (cnt == SETUP_LAST)     state_nx = PB_STRB;
            PB_STRB: if (finish)                state_nx = PB_END;
            PB_END:                             state_nx = PB_IDLE;
            default:                            state_nx = PB_IDLE;
        endcase
    end

    // Phase counter restarts when idle and at the strobe edge.
    assign cnt_clr = (state == PB_IDLE) || (state == PB_ADDR && cnt == SETUP_LAST);
    assign cnt_en  = !cnt_clr && (state != PB_END);
    assign tmo_set = finish && !bus_rdy;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PB_IDLE;
        else        state <= state_nx;
    end

    // Capture the request when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            bus_addr <= '0;
            bus_dout <= '0;
        end else if (state == PB_IDLE && req_valid) begin
            wr_q     <= req_write;
            bus_addr <= req_addr;
            bus_dout <= req_wdata;
        end
    end

    // Capture read data on the ending edge.
    always_ff @(posedge clk) begin
        if (!rst_n)               rsp_rdata <= '0;
        else if (finish && !wr_q) rsp_rdata <= bus_din;
    end

    // Bus and processor-side outputs decoded from the phase.
    assign bus_addr_oe = (state != PB_IDLE);
    assign bus_dout_oe = wr_q && (state == PB_ADDR || state == PB_STRB);
    assign bus_wr_n    = !(in_strb && wr_q);
    assign bus_rd_n    = !(in_strb && !wr_q);
    assign bus_out_n   = !(in_strb && wr_q && cnt >= OUT_AT);
    assign cpu_wait    = (state != PB_IDLE);
    assign rsp_done    = (state == PB_END);

    // R2/R4: write and read strobes never overlap
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n));
    // R3: data latch strobe never on a read
    a_r3_no_latch_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> bus_out_n);
    // R4: data drivers stay off under the read strobe
    a_r4_hiz_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_dout_oe);
    // R5: processor held while any strobe is low
    a_r5_wait_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_rd_n || !bus_out_n) |-> cpu_wait);
    // R11: address stays put during a cycle
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && $past(cpu_wait)) |-> $stable(bus_addr));
    // R9: end cycle lasts one clock
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: rtl/pb_bus_ctrl.sv
// Module: pb_bus_ctrl (top)
// Peripheral bus cycle controller: sequencer, phase timer and status.
// Assumes one clock domain; delays are given in clock cycles.
module pb_bus_ctrl #(
    parameter int AW          = 6,
    parameter int DW          = 8,
    parameter int SETUP_CYC   = 3,
    parameter int OUT_DLY     = 13,
    parameter int SAMPLE_CYC  = 38,
    parameter int TIMEOUT_CYC = 2700,
    parameter int SYNC_N      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          stat_clr,
    output logic          cpu_wait,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          tmo_flag,
    output logic          dev_irq,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    input  logic [DW-1:0] bus_din,
    output logic          bus_wr_n,
    output logic          bus_out_n,
    output logic          bus_rd_n,
    input  logic          bus_rdy,
    input  logic          bus_int_n
);
    localparam int CW = $clog2(TIMEOUT_CYC + SETUP_CYC + 1) + 1;

    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cnt_en;
    logic          tmo_set;

    pb_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .count (cnt)
    );

    pb_seq #(
        .AW(AW), .DW(DW), .CW(CW),
        .SETUP_CYC(SETUP_CYC), .OUT_DLY(OUT_DLY),
        .SAMPLE_CYC(SAMPLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_din     (bus_din),
        .bus_rdy     (bus_rdy),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .tmo_set     (tmo_set),
        .cpu_wait    (cpu_wait),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .bus_addr    (bus_addr),
        .bus_addr_oe (bus_addr_oe),
        .bus_dout    (bus_dout),
        .bus_dout_oe (bus_dout_oe),
        .bus_wr_n    (bus_wr_n),
        .bus_out_n   (bus_out_n),
        .bus_rd_n    (bus_rd_n)
    );

    pb_status #(.SYNC_N(SYNC_N)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_set   (tmo_set),
        .stat_clr  (stat_clr),
        .bus_int_n (bus_int_n),
        .tmo_flag  (tmo_flag),
        .dev_irq   (dev_irq)
    );
endmodule

// File: tb/pb_bus_ctrl_tb.sv
module pb_bus_ctrl_tb;
    localparam int S  = 3;
    localparam int OD = 13;
    localparam int SM = 38;
    localparam int TO = 2700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, stat_clr = 1'b0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0, bus_din = '0;
    logic bus_rdy = 1'b0, bus_int_n = 1'b1;
    logic cpu_wait, rsp_done, tmo_flag, dev_irq, bus_addr_oe, bus_dout_oe;
    logic bus_wr_n, bus_out_n, bus_rd_n;
    logic [7:0] rsp_rdata, bus_dout;
    logic [5:0] bus_addr;

    int checks = 0, errors = 0, cycles = 0;
    bit started = 0;

    always #10 clk = ~clk;

    pb_bus_ctrl #(.SETUP_CYC(S), .OUT_DLY(OD), .SAMPLE_CYC(SM), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .stat_clr(stat_clr),
        .cpu_wait(cpu_wait), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .tmo_flag(tmo_flag), .dev_irq(dev_irq), .bus_addr(bus_addr),
        .bus_addr_oe(bus_addr_oe), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
        .bus_din(bus_din), .bus_wr_n(bus_wr_n), .bus_out_n(bus_out_n),
        .bus_rd_n(bus_rd_n), .bus_rdy(bus_rdy), .bus_int_n(bus_int_n)
    );

    // Behavioural reference model: edges counted since acceptance.
    bit m_busy, m_end, m_wr, m_flag;
    int m_n;
    logic [5:0] m_addr;
    logic [7:0] m_data, m_rdata;
    bit m_s1, m_s2;

    always @(posedge clk) begin
        bit fin;
        fin = 0;
        if (!rst_n) begin
            m_busy = 0; m_end = 0; m_wr = 0; m_flag = 0; m_n = 0;
            m_addr = '0; m_data = '0; m_rdata = '0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1; m_s1 = !bus_int_n;
            if (m_end) begin
                m_end = 0; m_busy = 0;
            end else if (m_busy) begin
                if (m_n >= S + 1 && (m_n - S - 1) >= SM - 1 &&
                    (bus_rdy || (m_n - S - 1) == TO - 1)) begin
                    fin = 1; m_end = 1;
                    if (!m_wr) m_rdata = bus_din;
                end else m_n++;
            end else if (req_valid) begin
                m_busy = 1; m_n = 1; m_wr = req_write;
                m_addr = req_addr; m_data = req_wdata;
            end
            if (fin && !bus_rdy) m_flag = 1;
            else if (stat_clr)   m_flag = 0;
        end
        started = 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        bit strb;
        cycles++;
        if (started) begin
            strb = m_busy && !m_end && m_n >= S + 1;
            chk("R5", "cpu_wait", cpu_wait, m_busy);
            chk("R2", "addr_oe", bus_addr_oe, m_busy);
            if (m_busy) chk("R11", "bus_addr", bus_addr, m_addr);
            chk("R4", "dout_oe", bus_dout_oe, m_busy && m_wr && !m_end);
            if (m_busy && m_wr && !m_end) chk("R2", "bus_dout", bus_dout, m_data);
            chk("R2", "wr_n", bus_wr_n, !(strb && m_wr));
            chk("R4", "rd_n", bus_rd_n, !(strb && !m_wr));
            chk("R3", "out_n", bus_out_n, !(strb && m_wr && m_n >= S + 1 + OD));
            chk("R9", "done", rsp_done, m_end);
            if (m_end && !m_wr) chk("R9", "rdata", rsp_rdata, m_rdata);
            chk("R8", "tmo_flag", tmo_flag, m_flag);
            chk("R12", "dev_irq", dev_irq, m_s2);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One bus cycle; returns negedges from acceptance to rsp_done.
    task automatic run_cycle(input bit wr, input logic [5:0] a, input logic [7:0] d,
                             input int rdy_at, input bit early, input int clr_at,
                             input int busy_req_at, output int lat);
        int k;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        if (early) bus_rdy = 1;
        @(negedge clk);
        req_valid = 0;
        k = 1;
        forever begin
            if (rsp_done) break;
            stat_clr = (k == clr_at);
            if (k == rdy_at) bus_rdy = 1;
            if (k == busy_req_at) begin
                req_valid = 1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
            end else req_valid = 0;
            @(negedge clk);
            k++;
        end
        stat_clr = 0; req_valid = 0; bus_rdy = 0;
        lat = k;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "wr_n", bus_wr_n, 1); chk("R1", "rd_n", bus_rd_n, 1);
        chk("R1", "out_n", bus_out_n, 1); chk("R1", "oe", bus_addr_oe | bus_dout_oe, 0);
        chk("R1", "wait", cpu_wait | rsp_done | tmo_flag, 0);
        rst_n = 1;
        @(negedge clk);

        // R6: write with ready already high, ends at the first sample point
        run_cycle(1, 6'h2A, 8'hC3, -1, 1, -1, -1, lat);
        chk("R6", "early-ready latency", lat, S + SM + 1);

        // R7/R9: read with late ready
        bus_din = 8'h5E;
        run_cycle(0, 6'h15, 8'h00, 60, 0, -1, -1, lat);
        chk("R7", "late-ready latency", lat, 61);
        chk("R9", "read data", rsp_rdata, 8'h5E);

        // R7: ready rising just at the first sample point
        run_cycle(0, 6'h01, 8'h00, S + SM, 0, -1, -1, lat);
        chk("R7", "edge-ready latency", lat, S + SM + 1);

        // R11: request while busy is ignored
        run_cycle(1, 6'h3F, 8'h81, 50, 0, -1, 5, lat);
        chk("R11", "busy-req latency", lat, 51);
        chk("R11", "idle after", cpu_wait, 0);

        // R8: write timeout
        run_cycle(1, 6'h0C, 8'h77, -1, 0, -1, -1, lat);
        chk("R8", "timeout latency", lat, S + TO + 1);
        chk("R8", "flag set", tmo_flag, 1);

        // R10: lone clear
        stat_clr = 1; @(negedge clk); stat_clr = 0;
        chk("R10", "flag cleared", tmo_flag, 0);

        // R10: timeout on the same edge as a clear, set wins
        run_cycle(0, 6'h22, 8'h00, -1, 0, S + TO, -1, lat);
        chk("R10", "set wins", tmo_flag, 1);
        stat_clr = 1; @(negedge clk); stat_clr = 0;

        // R12: device interrupt passthrough
        bus_int_n = 0;
        repeat (3) @(negedge clk);
        chk("R12", "irq asserted", dev_irq, 1);
        bus_int_n = 1;
        repeat (3) @(negedge clk);
        chk("R12", "irq released", dev_irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule